// File: doc/BRIEF.md
# Serial Command Decoder Sequencer

This block sits behind a byte-wide serial receiver. It takes each received byte together with its valid strobe and treats the first byte of a transaction as a control word. It recognises seven fixed opcodes. It then counts in the number of data bytes that opcode requires, which is between zero and three. When the last byte of the transaction has been taken, it raises a one-clock completion strobe on the line that belongs to that command. The collected data bytes and any two-bit parameter field from the opcode are presented with the strobe. The destination sub-controllers use them: channel masking, threshold converter loading, hit-count readout, test pulsing, counting window and channel routing.

The sequencer is a one-hot state machine. Its state encodes how many data bytes are still owed. Bytes that arrive while data is owed are never decoded as opcodes. A byte that is not a known opcode is dropped while the block waits for a control word. A transaction that stalls for longer than a programmable number of idle clocks is abandoned, and the block waits for a fresh control word.

Top module: `cmd_seq`

## Requirements
- R1: After reset `cmd_done`, `cmd_payload` and `cmd_field` are all zero, and the first accepted byte is decoded as a control word.
- R2: Opcode 8'h20 (mask write) takes 3 data bytes, then pulses `cmd_done[0]`. `cmd_payload` holds the first data byte in [7:0], the second in [15:8] and the third in [23:16].
- R3: Opcode 8'h60 (mask read) takes no data and pulses `cmd_done[1]`, with `cmd_payload` zero.
- R4: Opcode 8'h10 (threshold write) takes 2 data bytes, then pulses `cmd_done[2]`. The bytes land in [7:0] and [15:8], and [23:16] reads zero.
- R5: Opcode 8'h50 (count read) takes 1 data byte, then pulses `cmd_done[3]`, with that byte in [7:0] and the rest zero.
- R6: Opcode 8'b000010tt (test pulse) takes no data and pulses `cmd_done[4]`, with `cmd_field` = tt.
- R7: Opcode 8'b000001ww (window width) takes no data and pulses `cmd_done[5]`, with `cmd_field` = ww.
- R8: Opcode 8'hC0 (channel select) takes 1 data byte, then pulses `cmd_done[6]`, with that byte in [7:0].
- R9: `cmd_done` rises in the clock after the edge that samples the final byte of a transaction and stays high for exactly that one clock. At most one bit is set, and it is never set after a byte that is not final. A data byte is never decoded as an opcode, whatever its value. `cmd_payload` and `cmd_field` hold until the next control word is accepted.
- R10: A byte received while waiting for a control word that matches no opcode produces no strobe, and the block keeps waiting for a control word.
- R11: While data bytes are owed, a gap of up to `GAP_LIMIT`-1 idle clocks between bytes is accepted. A gap of `GAP_LIMIT` idle clocks abandons the transaction without a strobe, and the next byte is decoded as a control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Byte strobe, one clock per byte |
| cmd_done | output | 7 | One-clock completion strobe, one bit per command |
| cmd_payload | output | 24 | Collected data bytes, first byte lowest |
| cmd_field | output | 2 | Two-bit parameter from the opcode |

## Verification
Every result here appears one register after the edge that samples the byte that causes it. The completion strobe, payload and field are therefore due in the clock right after the final byte's sampling edge. The bench drives each byte on a falling edge and compares the outputs on the very next falling edge. It samples once more one clock later to see the strobe gone and the payload held. For the timeout, the gap is counted in falling edges with the strobe low, so the gaps of `GAP_LIMIT`-1 and `GAP_LIMIT` land on the exact edges where acceptance and abandonment diverge.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_DATA = 3;
    localparam int N_CMD    = 7;
    localparam int LEN_W    = 2;
    localparam int FIELD_W  = 2;

    typedef enum logic [2:0] {
        CMD_MASK_WR  = 3'd0,
        CMD_MASK_RD  = 3'd1,
        CMD_THR_WR   = 3'd2,
        CMD_CNT_RD   = 3'd3,
        CMD_PULSE    = 3'd4,
        CMD_WINDOW   = 3'd5,
        CMD_CHAN_SEL = 3'd6
    } cmd_e;

    typedef struct packed {
        logic               hit;
        cmd_e               cmd;
        logic [LEN_W-1:0]   len;
        logic [FIELD_W-1:0] field;
    } cw_info_t;

    function automatic cw_info_t decode_cw(input logic [BYTE_W-1:0] b);
        cw_info_t r;
        r.hit   = 1'b0;
        r.cmd   = CMD_MASK_WR;
        r.len   = '0;
        r.field = '0;
        casez (b)
            8'b0010_0000: begin r.hit = 1'b1; r.cmd = CMD_MASK_WR;  r.len = 2'd3; end
            8'b0110_0000: begin r.hit = 1'b1; r.cmd = CMD_MASK_RD;  r.len = 2'd0; end
            8'b0001_0000: begin r.hit = 1'b1; r.cmd = CMD_THR_WR;   r.len = 2'd2; end
            8'b0101_0000: begin r.hit = 1'b1; r.cmd = CMD_CNT_RD;   r.len = 2'd1; end
            8'b0000_10??: begin r.hit = 1'b1; r.cmd = CMD_PULSE;    r.field = b[1:0]; end
            8'b0000_01??: begin r.hit = 1'b1; r.cmd = CMD_WINDOW;   r.field = b[1:0]; end
            8'b1100_0000: begin r.hit = 1'b1; r.cmd = CMD_CHAN_SEL; r.len = 2'd1; end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
    import cmd_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output cw_info_t          info
);

    always_comb begin
        info = decode_cw(byte_in);
    end

endmodule

// File: rtl/cmd_seq_gap_timer.sv
module cmd_seq_gap_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(LIMIT)); // R11

    AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R11

endmodule

// File: rtl/cmd_seq_collector.sv
module cmd_seq_collector
    import cmd_seq_pkg::*;
#(
    parameter int SLOTS = MAX_DATA
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    load,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic [SLOTS*BYTE_W-1:0] payload
);

    logic [SLOTS-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= SLOTS'(1);
        end else if (load) begin
            ptr <= ptr << 1;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                payload[i*BYTE_W +: BYTE_W] <= '0;
            end else if (load && ptr[i]) begin
                payload[i*BYTE_W +: BYTE_W] <= byte_in;
            end
        end
    end

    AST_SLOT_PTR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ptr)); // R2

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load) |=> $stable(payload)); // R9

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import cmd_seq_pkg::*;
#(
    parameter int GAP_LIMIT = 1000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [7:0]                   rx_byte,
    input  logic                         rx_valid,
    output logic [6:0]                   cmd_done,
    output logic [23:0]                  cmd_payload,
    output logic [1:0]                   cmd_field
);

    localparam int ST_W = MAX_DATA + 1;

    // st[r] set means r data bytes still owed; st[0] is the idle state.
    logic [ST_W-1:0]    st;
    cw_info_t           info;
    cmd_e               pend_cmd;
    logic               idle;
    logic               take_cw;
    logic               take_dat;
    logic               last_dat;
    logic               gap_run;
    logic               gap_expire;

    cmd_seq_decode u_decode (
        .byte_in (rx_byte),
        .info    (info)
    );

    assign idle     = st[0];
    assign take_cw  = rx_valid && idle && info.hit;
    assign take_dat = rx_valid && !idle;
    assign last_dat = take_dat && st[1];
    assign gap_run  = !idle && !rx_valid;

    cmd_seq_gap_timer #(
        .LIMIT (GAP_LIMIT)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .run    (gap_run),
        .expire (gap_expire)
    );

    cmd_seq_collector #(
        .SLOTS (MAX_DATA)
    ) u_collect (
        .clk     (clk),
        .rst     (rst),
        .clear   (take_cw),
        .load    (take_dat),
        .byte_in (rx_byte),
        .payload (cmd_payload)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_W'(1);
        end else if (take_cw) begin
            st <= ST_W'(1) << info.len;
        end else if (take_dat) begin
            st <= st >> 1;
        end else if (gap_expire) begin
            st <= ST_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cmd  <= CMD_MASK_WR;
            cmd_field <= '0;
        end else if (take_cw) begin
            pend_cmd  <= info.cmd;
            cmd_field <= info.field;
        end
    end

    always_ff @(posedge clk) begin
        cmd_done <= '0;
        if (rst) begin
            cmd_done <= '0;
        end else if (take_cw && (info.len == '0)) begin
            cmd_done[info.cmd] <= 1'b1;
        end else if (last_dat) begin
            cmd_done[pend_cmd] <= 1'b1;
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_done)); // R9

    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (cmd_done != '0) |-> $past(rx_valid)); // R9

    AST_DATA_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!st[0] && rx_valid) |=> (st == ($past(st) >> 1))); // R9

    AST_JUNK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st[0] && rx_valid && !info.hit) |=> (st[0] && cmd_done == '0)); // R10

    AST_GAP_ABORT: assert property (@(posedge clk) disable iff (rst)
        gap_expire |=> (st[0] && cmd_done == '0)); // R11

endmodule

// File: tb/cmd_seq_test.sv
module cmd_seq_test;

    localparam int GAP = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [6:0]  cmd_done;
    logic [23:0] cmd_payload;
    logic [1:0]  cmd_field;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmd_seq #(.GAP_LIMIT(GAP)) uut (
        .clk         (clk),
        .rst         (rst),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .cmd_done    (cmd_done),
        .cmd_payload (cmd_payload),
        .cmd_field   (cmd_field)
    );

    task automatic check(input string req, input logic [6:0] ed,
                         input logic [23:0] ep, input logic [1:0] ef);
        n_checks++;
        if (cmd_done !== ed || cmd_payload !== ep || cmd_field !== ef) begin
            n_fail++;
            $display("FAIL %s: done=%b payload=%h field=%0d, expected done=%b payload=%h field=%0d",
                     req, cmd_done, cmd_payload, cmd_field, ed, ep, ef);
        end
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic bit is_opcode(input logic [7:0] b);
        return b == 8'h20 || b == 8'h60 || b == 8'h10 || b == 8'h50 ||
               b == 8'hC0 || b[7:2] == 6'b000010 || b[7:2] == 6'b000001;
    endfunction

    function automatic int len_of(input int kind);
        case (kind)
            0: return 3;
            2: return 2;
            3, 6: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] opcode_of(input int kind, input logic [1:0] f);
        case (kind)
            0: return 8'h20;
            1: return 8'h60;
            2: return 8'h10;
            3: return 8'h50;
            4: return {6'b000010, f};
            5: return {6'b000001, f};
            default: return 8'hC0;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 7'h00, 24'h0, 2'd0);
        send(8'h60, 0);
        check("R1 first byte is control word", 7'h02, 24'h0, 2'd0);

        // Mask write with three bytes, strobe only after the third
        send(8'h20, 0);
        send(8'hA1, 0);
        check("R9 no strobe after non-final byte", 7'h00, 24'h0000A1, 2'd0);
        send(8'hB2, 0);
        send(8'hC3, 0);
        check("R2 mask write", 7'h01, 24'hC3B2A1, 2'd0);
        @(negedge clk);
        check("R9 strobe one clock, payload held", 7'h00, 24'hC3B2A1, 2'd0);

        send(8'h10, 0); send(8'h33, 0); send(8'h44, 0);
        check("R4 threshold write", 7'h04, 24'h004433, 2'd0);

        // Data byte equal to an opcode must not be decoded
        send(8'h50, 0); send(8'h60, 0);
        check("R5 count read, R9 data not decoded", 7'h08, 24'h000060, 2'd0);

        send(8'h0B, 0);
        check("R6 test pulse field 3", 7'h10, 24'h0, 2'd3);
        send(8'h05, 0);
        check("R7 window field 1, back to back", 7'h20, 24'h0, 2'd1);
        @(negedge clk);
        check("R7 field held", 7'h00, 24'h0, 2'd1);

        send(8'hC0, 0); send(8'h7E, 0);
        check("R8 channel select", 7'h40, 24'h00007E, 2'd0);

        send(8'h30, 0);
        check("R10 unknown opcode ignored", 7'h00, 24'h00007E, 2'd0);
        send(8'hFF, 0);
        check("R10 unknown opcode ignored again", 7'h00, 24'h00007E, 2'd0);
        send(8'h60, 0);
        check("R10 still waiting for control word", 7'h02, 24'h0, 2'd0);

        // Longest accepted gaps
        send(8'h20, 0);
        send(8'h11, GAP - 1);
        send(8'h22, GAP - 1);
        send(8'h33, GAP - 1);
        check("R11 gap of limit-1 accepted", 7'h01, 24'h332211, 2'd0);

        // Gap of exactly the limit abandons the transaction
        send(8'h10, 0);
        send(8'h55, 0);
        send(8'h60, GAP);
        check("R11 abort then opcode decoded", 7'h02, 24'h0, 2'd0);

        send(8'hC0, 0);
        send(8'h09, GAP);
        check("R11 abort then test pulse", 7'h10, 24'h0, 2'd1);

        // Constrained random transactions
        void'($urandom(32'd4711));
        for (int t = 0; t < 400; t++) begin
            int          kind;
            int          len;
            logic [1:0]  f;
            logic [23:0] ep;
            logic [7:0]  b;
            int          gp;
            kind = int'($urandom_range(0, 7));
            f    = 2'($urandom_range(0, 3));
            gp   = int'($urandom_range(0, 3));
            if (kind == 7) begin
                b = 8'($urandom_range(0, 255));
                while (is_opcode(b)) b = b + 8'd1;
                send(b, gp);
                check("R10 random junk", 7'h00, cmd_payload, cmd_field);
            end else begin
                len = len_of(kind);
                ep  = '0;
                send(opcode_of(kind, f), gp);
                for (int k = 0; k < len; k++) begin
                    if (k > 0) check("R9 random no early strobe", 7'h00, ep, 2'd0);
                    b  = 8'($urandom_range(0, 255));
                    ep = ep | (24'(b) << (8 * k));
                    send(b, int'($urandom_range(0, GAP - 1)));
                end
                case (kind)
                    0: check("R2 random", 7'h01, ep, 2'd0);
                    1: check("R3 random", 7'h02, ep, 2'd0);
                    2: check("R4 random", 7'h04, ep, 2'd0);
                    3: check("R5 random", 7'h08, ep, 2'd0);
                    4: check("R6 random", 7'h10, ep, f);
                    5: check("R7 random", 7'h20, ep, f);
                    default: check("R8 random", 7'h40, ep, 2'd0);
                endcase
                if ($urandom_range(0, 3) == 0) begin
                    @(negedge clk);
                    check("R9 random strobe width",
                          7'h00, ep, (kind == 4 || kind == 5) ? f : 2'd0);
                end
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule